// File: doc/BRIEF.md
# Transmit Queue to DMA Channel Steering Arbiter

This block decides, once per clock, which transmit queue hands its next frame descriptor to which transmit DMA channel. Up to sixteen queues each present a pending-descriptor count. Every queue is bound to exactly one of eight channels, and several queues may share a channel. Channels 0 to 3 carry data traffic classes in rising priority: background, best effort, video, and voice with management. Channels 4 to 6 carry no assigned traffic. Channel 7 carries commands.

Selection runs at two levels. Among the channels whose consumer is ready and that have at least one eligible queue, the highest-numbered channel wins, so the command channel always comes first. Inside the winning channel, the queues bound to it are served round-robin, starting with the queue after the one served last on that channel. The chosen descriptor is claimed from its queue with a one-cycle take strobe. It is then held in a single output slot until the channel accepts it.

Each queue is configured through a status word. That word holds the channel number, an active flag and a block-ack mode flag. The channel binding can only be changed while the queue is inactive. The command channel always runs in plain in-order mode.

Top module: `txs_steer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no channel valid and no queue take is raised; after reset every queue is inactive and bound to channel 0.
- R2: A queue whose active flag is clear is never taken, whatever its pending count.
- R3: A queue is steered only to the channel held in bits 2:0 of its status word, and ch_qid names that queue while the descriptor is presented.
- R4: A ready command channel (7) with an eligible queue wins over every data channel.
- R5: Among channels 0 to 6, the highest-numbered channel that is ready and has an eligible queue wins.
- R6: Queues bound to one channel are served round-robin, starting after the queue that channel served last; after reset the search on every channel starts at queue 0.
- R7: At most one queue take and at most one channel valid are high in any cycle.
- R8: While a presented descriptor's channel holds ready low, ch_valid, ch_qid and ch_ackmode stay unchanged.
- R9: A status write always updates the active flag (bit 3) and the ack flag (bit 19), but it changes the channel field only if the queue was inactive before the write.
- R10: A queue bound to channel 7 always has its ack flag cleared, whatever bit 19 of the write holds; for other channels ch_ackmode reports the queue's ack flag.
- R11: A queue with a pending count of zero is never taken, and a channel whose ready input is low in a cycle is not chosen in that cycle.
- R12: A take strobe for a queue is followed on the next clock by ch_valid for its channel; a new choice is made only when the slot is empty or is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one queue status word |
| cfg_qid | input | 4 | Queue addressed by the write |
| cfg_wdata | input | 32 | Status word: channel [2:0], active [3], ack mode [19] |
| q_level | input | 128 | Pending descriptor count per queue, 8 bits each, queue n at [8n+7:8n] |
| q_take | output | 16 | One-cycle strobe that claims a descriptor from a queue |
| ch_ready | input | 8 | Per-channel consumer ready |
| ch_valid | output | 8 | Per-channel descriptor valid, at most one bit set |
| ch_qid | output | 4 | Queue that the presented descriptor came from |
| ch_ackmode | output | 1 | Block-ack mode flag of the presented descriptor |

## Verification
The hardest situation to reach is a change of queue binding that arrives while the queue is still being served. Here a write must leave the channel untouched but still update the flags, and a held descriptor must keep its identity. The stimulus reaches it with directed writes to an active queue, followed by deactivate-and-rebind writes. These are mixed with random status writes, random pending counts and random ready patterns, all issued while descriptors sit in the slot. Round-robin order and the command channel's precedence are driven directly, by loading several queues onto one channel and by making channel 7 and a data channel pending in the same cycle.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // status word field positions (decoded by the status registers)
  localparam int STAT_ACT_POS = 3;
  localparam int STAT_ACK_POS = 19;
  localparam int STAT_DW      = 32;
endpackage

// File: rtl/txs_qstatus.sv
module txs_qstatus
  import txs_pkg::*;
#(
  parameter int NQ     = 16,
  parameter int NCH    = 8,
  parameter int CMD_CH = NCH - 1,
  localparam int QW    = $clog2(NQ),
  localparam int CW    = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [QW-1:0]      wr_q,
  input  logic [STAT_DW-1:0] wr_data,
  output logic [NQ*CW-1:0]   q_chan,
  output logic [NQ-1:0]      q_act,
  output logic [NQ-1:0]      q_ack
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [CW-1:0] chan_r, chan_d;
    logic          act_r, act_d, ack_r, ack_d, sel;

    assign sel = wr_en && (wr_q == QW'(q));

    always_comb begin
      chan_d = chan_r;
      act_d  = act_r;
      ack_d  = ack_r;
      if (sel) begin
        if (!act_r) chan_d = wr_data[CW-1:0];
        act_d = wr_data[STAT_ACT_POS];
        ack_d = wr_data[STAT_ACK_POS] && (chan_d != CW'(CMD_CH));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_r <= '0;
        act_r  <= 1'b0;
        ack_r  <= 1'b0;
      end else if (sel) begin
        chan_r <= chan_d;
        act_r  <= act_d;
        ack_r  <= ack_d;
      end
    end

    assign q_chan[q*CW +: CW] = chan_r;
    assign q_act[q] = act_r;
    assign q_ack[q] = ack_r;
  end
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter int NQ  = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic [NQ-1:0] req,
  input  logic [QW-1:0] last,
  output logic          any,
  output logic [QW-1:0] idx
);
  always_comb begin
    int unsigned cand;
    any = 1'b0;
    idx = '0;
    // scan from farthest to nearest so the nearest request after 'last' wins
    for (int k = NQ; k >= 1; k--) begin
      cand = (int'(last) + k) % NQ;
      if (req[cand]) begin
        any = 1'b1;
        idx = QW'(cand);
      end
    end
  end
endmodule

// File: rtl/txs_ch_prio.sv
module txs_ch_prio #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] cand,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (cand[c]) begin
        any = 1'b1;
        idx = CW'(c);
      end
    end
  end
endmodule

// File: rtl/txs_steer.sv
module txs_steer
  import txs_pkg::*;
#(
  parameter int NQ    = 16,
  parameter int NCH   = 8,
  parameter int CNT_W = 8,
  localparam int QW   = $clog2(NQ),
  localparam int CW   = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [QW-1:0]      cfg_qid,
  input  logic [STAT_DW-1:0] cfg_wdata,
  input  logic [NQ*CNT_W-1:0] q_level,
  output logic [NQ-1:0]      q_take,
  input  logic [NCH-1:0]     ch_ready,
  output logic [NCH-1:0]     ch_valid,
  output logic [QW-1:0]      ch_qid,
  output logic               ch_ackmode
);
  logic [NQ*CW-1:0] q_chan;
  logic [NQ-1:0]    q_act, q_ack, q_pend;

  txs_qstatus #(.NQ(NQ), .NCH(NCH), .CMD_CH(NCH-1)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_q(cfg_qid),
    .wr_data(cfg_wdata), .q_chan(q_chan), .q_act(q_act), .q_ack(q_ack)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_pend
    assign q_pend[q] = q_act[q] && (q_level[q*CNT_W +: CNT_W] != '0);
  end

  // per-channel round-robin among bound queues
  logic [QW-1:0]  last_r [NCH];
  logic [QW-1:0]  last_d [NCH];
  logic [QW-1:0]  rr_idx [NCH];
  logic [NCH-1:0] rr_any, ch_cand;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NQ-1:0] req;
    for (genvar q = 0; q < NQ; q++) begin : g_req
      assign req[q] = q_pend[q] && (q_chan[q*CW +: CW] == CW'(c));
    end
    txs_rr_pick #(.NQ(NQ)) u_rr (
      .req(req), .last(last_r[c]), .any(rr_any[c]), .idx(rr_idx[c])
    );
    assign ch_cand[c] = rr_any[c] && ch_ready[c];
  end

  logic          win_any;
  logic [CW-1:0] win_ch;
  txs_ch_prio #(.NCH(NCH)) u_prio (.cand(ch_cand), .any(win_any), .idx(win_ch));

  // single output slot
  logic          slot_v_r, slot_v_d;
  logic [CW-1:0] slot_ch_r, slot_ch_d;
  logic [QW-1:0] slot_q_r, slot_q_d;
  logic          slot_ack_r, slot_ack_d;
  logic          accept, load, slot_en;
  logic [QW-1:0] win_q;

  assign win_q  = rr_idx[win_ch];
  assign accept = slot_v_r && ch_ready[slot_ch_r];
  assign load   = (!slot_v_r || accept) && win_any;
  assign slot_en = load || accept;

  always_comb begin
    slot_v_d   = slot_v_r;
    slot_ch_d  = slot_ch_r;
    slot_q_d   = slot_q_r;
    slot_ack_d = slot_ack_r;
    if (load) begin
      slot_v_d   = 1'b1;
      slot_ch_d  = win_ch;
      slot_q_d   = win_q;
      slot_ack_d = q_ack[win_q];
    end else if (accept) begin
      slot_v_d   = 1'b0;
    end
    for (int c = 0; c < NCH; c++) begin
      last_d[c] = last_r[c];
      if (load && (win_ch == CW'(c))) last_d[c] = win_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_r   <= 1'b0;
      slot_ch_r  <= '0;
      slot_q_r   <= '0;
      slot_ack_r <= 1'b0;
    end else if (slot_en) begin
      slot_v_r   <= slot_v_d;
      slot_ch_r  <= slot_ch_d;
      slot_q_r   <= slot_q_d;
      slot_ack_r <= slot_ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) last_r[c] <= QW'(NQ - 1);
    end else if (load) begin
      for (int c = 0; c < NCH; c++) last_r[c] <= last_d[c];
    end
  end

  always_comb begin
    q_take = '0;
    if (load) q_take[win_q] = 1'b1;
    ch_valid = '0;
    if (slot_v_r) ch_valid[slot_ch_r] = 1'b1;
  end

  assign ch_qid     = slot_q_r;
  assign ch_ackmode = slot_ack_r;
endmodule

// File: rtl/txs_steer_chk.sv
module txs_steer_chk #(
  parameter int NQ    = 16,
  parameter int NCH   = 8,
  parameter int CNT_W = 8,
  localparam int QW   = $clog2(NQ)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NQ*CNT_W-1:0] q_level,
  input logic [NQ-1:0]       q_take,
  input logic [NQ-1:0]       q_act,
  input logic [NCH-1:0]      ch_ready,
  input logic [NCH-1:0]      ch_valid,
  input logic [QW-1:0]       ch_qid,
  input logic                ch_ackmode
);
  assert_one_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_take));
  assert_one_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_valid));
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_valid & ~ch_ready)) |=> ($stable(ch_valid) && $stable(ch_qid) && $stable(ch_ackmode)));
  assert_cmd_noack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid[NCH-1] |-> !ch_ackmode);
  assert_take_then_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_take) |=> (|ch_valid));
  for (genvar q = 0; q < NQ; q++) begin : g_q
    assert_take_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_take[q] |-> q_act[q]);
    assert_take_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      q_take[q] |-> (q_level[q*CNT_W +: CNT_W] != '0));
  end
endmodule

bind txs_steer txs_steer_chk #(.NQ(NQ), .NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_level(q_level), .q_take(q_take), .q_act(q_act),
  .ch_ready(ch_ready), .ch_valid(ch_valid), .ch_qid(ch_qid), .ch_ackmode(ch_ackmode)
);

// File: tb/txs_steer_test.sv
module txs_steer_test;
  localparam int CLK_P = 10;
  localparam int NQ = 16, NCH = 8, CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_qid = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NQ*CNT_W-1:0] q_level = '0;
  logic [NQ-1:0] q_take;
  logic [NCH-1:0] ch_ready = '0;
  logic [NCH-1:0] ch_valid;
  logic [3:0] ch_qid;
  logic ch_ackmode;

  always #(CLK_P/2) clk = ~clk;

  txs_steer uut (.*);

  int total = 0, bad = 0;

  // reference state
  int  m_ch[NQ]; bit m_act[NQ]; bit m_ack[NQ]; int lvl[NQ]; int m_last[NCH];
  bit  sv; int sch, sq; bit sack;
  bit  wr_en; int wr_q; logic [31:0] wr_d;
  logic [NCH-1:0] rdy;

  task automatic chk(bit ok, string tag, string what, longint a, longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, a, e);
    end
  endtask

  function automatic logic [31:0] sword(int ch, bit act, bit ack);
    return (32'(ack) << 19) | (32'(act) << 3) | 32'(ch & 7);
  endfunction

  task automatic step(string tag);
    logic [NQ-1:0] et; logic [NCH-1:0] ev; bit ld; int pc, pq;
    @(negedge clk);
    cfg_we = wr_en; cfg_qid = 4'(wr_q); cfg_wdata = wr_d;
    ch_ready = rdy;
    for (int q = 0; q < NQ; q++) q_level[q*CNT_W +: CNT_W] = CNT_W'(lvl[q]);
    #1;
    ev = sv ? (NCH'(1) << sch) : '0;
    ld = 0; pc = 0; pq = 0;
    if (!sv || rdy[sch]) begin
      for (int c = NCH-1; c >= 0 && !ld; c--) begin
        if (rdy[c]) begin
          for (int k = 1; k <= NQ && !ld; k++) begin
            int q = (m_last[c] + k) % NQ;
            if (m_act[q] && m_ch[q] == c && lvl[q] > 0) begin ld = 1; pc = c; pq = q; end
          end
        end
      end
    end
    et = ld ? (NQ'(1) << pq) : '0;
    chk(q_take == et, tag, "q_take", q_take, et);
    chk(ch_valid == ev, tag, "ch_valid", ch_valid, ev);
    if (sv) begin
      chk(ch_qid == 4'(sq), tag, "ch_qid", ch_qid, sq);
      chk(ch_ackmode == sack, tag, "ch_ackmode", ch_ackmode, sack);
    end
    chk($countones(q_take) <= 1, "R7", "take count", $countones(q_take), 1);
    if (ld) begin
      sv = 1; sch = pc; sq = pq; sack = m_ack[pq]; m_last[pc] = pq; lvl[pq]--;
    end else if (sv && rdy[sch]) sv = 0;
    if (wr_en) begin
      if (!m_act[wr_q]) m_ch[wr_q] = int'(wr_d[2:0]);
      m_act[wr_q] = wr_d[3];
      m_ack[wr_q] = wr_d[19] && (m_ch[wr_q] != 7);
    end
    wr_en = 0;
  endtask

  task automatic wr(int q, logic [31:0] d, string tag);
    wr_en = 1; wr_q = q; wr_d = d;
    step(tag);
  endtask

  initial begin
    #(CLK_P*200000);
    bad++; total++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int q = 0; q < NQ; q++) begin m_ch[q] = 0; m_act[q] = 0; m_ack[q] = 0; lvl[q] = 2; end
    for (int c = 0; c < NCH; c++) m_last[c] = NQ - 1;
    sv = 0; sch = 0; sq = 0; sack = 0; wr_en = 0; wr_q = 0; wr_d = '0; rdy = '1;
    // R1: outputs quiet during reset
    repeat (2) @(negedge clk);
    chk(ch_valid == 0, "R1", "valid in reset", ch_valid, 0);
    chk(q_take == 0, "R1", "take in reset", q_take, 0);
    rst_n = 1'b1;
    // R1/R2: all queues inactive after reset though counts are pending
    repeat (3) step("R1");
    wr(2, sword(1, 0, 0), "R2");
    repeat (3) step("R2");
    // R3 / R9: bind q5 to channel 2, then attempt rebind while active
    for (int q = 0; q < NQ; q++) lvl[q] = 0;
    lvl[5] = 6;
    wr(5, sword(2, 1, 0), "R3");
    repeat (2) step("R3");
    wr(5, sword(0, 1, 1), "R9");
    repeat (3) step("R9");
    wr(5, sword(0, 0, 0), "R9");
    wr(5, sword(0, 1, 0), "R9");
    repeat (3) step("R9");
    // R10: ack ignored on command channel, honoured on a data channel
    lvl[9] = 2; lvl[4] = 2;
    wr(9, sword(7, 1, 1), "R10");
    wr(4, sword(3, 1, 1), "R10");
    // R4: channel 7 and channel 3 pending at once
    lvl[9] = 2; lvl[4] = 2;
    repeat (6) step("R4");
    // R6: three queues on channel 1, only channel 1 ready
    for (int q = 10; q <= 12; q++) begin lvl[q] = 2; wr(q, sword(1, 1, 0), "R6"); end
    rdy = 8'h02;
    repeat (8) step("R6");
    // R8: held slot while ready is low
    lvl[13] = 1;
    wr(13, sword(0, 1, 0), "R8");
    rdy = 8'h01; step("R8");
    rdy = 8'h00; repeat (3) step("R8");
    rdy = 8'h01; repeat (2) step("R12");
    // R11: ready only on a channel without pending queues
    lvl[10] = 3; rdy = 8'h20; repeat (3) step("R11");
    // R5: random traffic, random bindings, random readiness
    for (int n = 0; n < 4000; n++) begin
      rdy = NCH'($urandom | $urandom);
      for (int q = 0; q < NQ; q++) if (lvl[q] == 0 && $urandom % 4 == 0) lvl[q] = int'($urandom % 4);
      if ($urandom % 8 == 0) begin
        wr_en = 1; wr_q = int'($urandom % NQ);
        wr_d = sword(int'($urandom % 8), ($urandom % 5) != 0, $urandom % 2);
      end
      step("R5");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule